// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port with a small memory-mapped register interface. The bus consists of an address, a write enable, write data and registered read data, all on one clock. The port keeps a data register and a direction register. Software reaches the data register through a window of addresses. In that window the address itself says which pins an access touches, so software can change one pin without first reading the port and then writing it back.

Each pin output is resolved on every clock. An output pin drives its data bit. An input pin drives its pull level when a pull-up or pull-down is configured through a parameter. When neither pull is configured, the input pin holds the value it last drove. External levels on input pins are captured into the data register on every clock. A fixed set of identification bytes can be read at the top of the 4 KiB space.

Top module: `gpio_mask_port`

## Requirements
- R1: During and after reset, the data and direction registers and the read data are 0. Each pin output drives 1 where its pull-up parameter bit is set, and 0 everywhere else.
- R2: A read at a byte offset from 0x000 to 0x3FF returns the data register ANDed with the pin mask taken from address bits [9:2]. All other bits of the read data are 0. Read data appears on the clock edge that follows the edge at which the address is sampled.
- R3: A write in the data window changes a data bit only when its pin is selected by the address mask and its direction bit is 1. Every other data bit of an output pin keeps its value.
- R4: Offset 0x400 holds the direction register. Bit n = 1 makes pin n an output. A write there stores only the low 8 bits of the write data, and a read there returns the stored value.
- R5: On every clock, the data bit of each input pin (direction 0) takes the level on that pin's input. The inputs of output pins are ignored.
- R6: One clock after the registers change, each output pin drives its data bit. An input pin with its pull-up bit set drives 1, and an input pin with its pull-down bit set drives 0.
- R7: An input pin with neither pull bit set keeps driving the value it drove on the previous clock. This includes a pin that was just switched from output to input.
- R8: The word offsets 0xFD0 through 0xFFC read, in ascending address order, the bytes 0x00, 0x00, 0x00, 0x00, 0x61, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Reads at any other offset return 0. Writes to any other offset change neither the registers nor the pins.
- R10: A masked data write and an input capture in the same clock do not disturb each other. Output bits take the write, and input bits take the pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the access; bits [1:0] are ignored |
| busWrEn | input | 1 | Write strobe for the current address |
| busWrData | input | 32 | Write data; only the low 8 bits are used |
| busRdData | output | 32 | Registered read data for the previous address |
| pinIn | input | 8 | External levels on the pins |
| pinOut | output | 8 | Resolved level driven on each pin |

## Verification
The two functions that can act in the same cycle are the bus write to the data register and the capture of external levels into that register's input bits. Both are provoked in one edge: a full-mask write of all ones arrives while the input-pin levels drop to zero. The bench then reads the data back and checks that the output bits took the written ones and the input bits took the zeros. A second overlap is a direction write issued in the same cycle as a capture. In that case the capture must use the old direction and the pin drive must use the new one. The expected pin values, including the floating-hold bits, are judged from those rules.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DATA = 2'd1,
    RD_DIR  = 2'd2,
    RD_ID   = 2'd3
  } rdSel_e;

  // Strobes from the address decoder to the datapath
  typedef struct packed {
    logic       dataWr;
    logic       dirWr;
    rdSel_e     rdSel;
    logic [3:0] idIdx;
  } portStrobe_t;

  localparam int ID_COUNT = 12;

  function automatic logic [7:0] idByte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd4:    b = 8'h61;
      4'd5:    b = 8'h10;
      4'd6:    b = 8'h04;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_PINS = 8
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  output portStrobe_t         strobe,
  output logic [NUM_PINS-1:0] selMask
);

  localparam int WORD_W = ADDR_W - 2;
  // The data window spans 2**NUM_PINS words; direction sits just above it
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << NUM_PINS;
  localparam logic [WORD_W-1:0] ID_FIRST = WORD_W'(12'hFD0 >> 2);
  localparam logic [WORD_W-1:0] ID_LAST  = ID_FIRST + WORD_W'(ID_COUNT - 1);

  logic [WORD_W-1:0] wordAddr;
  logic              inWindow;
  logic              inId;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign inWindow = (wordAddr >> NUM_PINS) == '0;
  assign inId     = (wordAddr >= ID_FIRST) && (wordAddr <= ID_LAST);
  assign selMask  = wordAddr[NUM_PINS-1:0];

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    if (inWindow) begin
      strobe.rdSel  = RD_DATA;
      strobe.dataWr = busWrEn;
    end else if (wordAddr == DIR_WORD) begin
      strobe.rdSel = RD_DIR;
      strobe.dirWr = busWrEn;
    end else if (inId) begin
      strobe.rdSel = RD_ID;
      strobe.idIdx = 4'(wordAddr - ID_FIRST);
    end
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell #(
  parameter bit PULL_HI = 1'b0,
  parameter bit PULL_LO = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic dirBit,
  input  logic wrHit,
  input  logic wrBit,
  input  logic padIn,
  output logic dataBit,
  output logic padOut
);

  logic dataNext;
  logic inputLevel;
  logic outNext;

  // The pull configuration picks how an input pin is driven
  generate
    if (PULL_HI) begin : g_up
      assign inputLevel = 1'b1;
    end else if (PULL_LO) begin : g_down
      assign inputLevel = 1'b0;
    end else begin : g_float
      assign inputLevel = padOut;
    end
  endgenerate

  always_comb begin
    if (dirBit) dataNext = wrHit ? wrBit : dataBit;
    else        dataNext = padIn;
  end

  assign outNext = dirBit ? dataBit : inputLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataBit <= 1'b0;
      padOut  <= PULL_HI;
    end else begin
      dataBit <= dataNext;
      padOut  <= outNext;
    end
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int                NUM_PINS  = 8,
  parameter int                DATA_W    = 32,
  parameter logic [NUM_PINS-1:0] PULL_UP   = '1,
  parameter logic [NUM_PINS-1:0] PULL_DOWN = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] selMask,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   busRdData,
  output logic [NUM_PINS-1:0] pinOut
);

  localparam logic [NUM_PINS-1:0] NO_PULL = ~(PULL_UP | PULL_DOWN);

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] dataVec;
  logic [DATA_W-1:0]   rdNext;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_cell #(
      .PULL_HI(PULL_UP[p]),
      .PULL_LO(PULL_DOWN[p])
    ) i_cell (
      .clk    (clk),
      .rstN   (rstN),
      .dirBit (dirReg[p]),
      .wrHit  (strobe.dataWr & selMask[p]),
      .wrBit  (busWrData[p]),
      .padIn  (pinIn[p]),
      .dataBit(dataVec[p]),
      .padOut (pinOut[p])
    );
  end

  always_comb begin
    case (strobe.rdSel)
      RD_DATA: rdNext = DATA_W'(dataVec & selMask);
      RD_DIR:  rdNext = DATA_W'(dirReg);
      RD_ID:   rdNext = DATA_W'(idByte(strobe.idIdx));
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg    <= '0;
      busRdData <= '0;
    end else begin
      if (strobe.dirWr) dirReg <= busWrData[NUM_PINS-1:0];
      busRdData <= rdNext;
    end
  end

  AST_DATA_WR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataWr |=> (dataVec & $past(dirReg & selMask)) ==
                      $past(busWrData[NUM_PINS-1:0] & dirReg & selMask)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataWr |=> ((dataVec ^ $past(dataVec)) & $past(dirReg)) == '0); // R5

  AST_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dataVec ^ $past(pinIn)) & ~$past(dirReg)) == '0); // R5

  AST_DIR_STORE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirWr |=> dirReg == $past(busWrData[NUM_PINS-1:0])); // R4

  AST_PULL_UP_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & PULL_UP & ~$past(dirReg)) == (PULL_UP & ~$past(dirReg))); // R6

  // Also fires when a pin is given both pulls, which is an illegal setting
  AST_PULL_DOWN_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & PULL_DOWN & ~$past(dirReg)) == '0); // R6

  AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut ^ $past(pinOut)) & NO_PULL & ~$past(dirReg)) == '0); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_NONE) |=> busRdData == '0); // R9

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          NUM_PINS  = 8,
  parameter logic [7:0]  PULL_UP   = 8'hFF,
  parameter logic [7:0]  PULL_DOWN = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [7:0]        pinIn,
  output logic [7:0]        pinOut
);

  portStrobe_t         strobe;
  logic [NUM_PINS-1:0] selMask;

  gpio_port_ctrl #(
    .ADDR_W  (ADDR_W),
    .NUM_PINS(NUM_PINS)
  ) i_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe),
    .selMask(selMask)
  );

  gpio_port_dp #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .PULL_UP  (PULL_UP),
    .PULL_DOWN(PULL_DOWN)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .selMask  (selMask),
    .busWrData(busWrData),
    .pinIn    (pinIn),
    .busRdData(busRdData),
    .pinOut   (pinOut)
  );

endmodule

// File: tb/test_gpio_mask_port.sv
`timescale 1ns/1ps
module test_gpio_mask_port;

  localparam logic [7:0] PU = 8'h0F;
  localparam logic [7:0] PD = 8'h30;  // bits 7:6 float

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [7:0]  pins;
    logic [31:0] expRd;
    logic [7:0]  expOut;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 12'h400, 32'h1F5, 8'h00, 32'hF5, 8'h0A, 4'd4},  // R4 low byte only
    '{1'b1, 12'h3FC, 32'hFF,  8'h00, 32'hF5, 8'hFF, 4'd3},  // R3 full mask
    '{1'b1, 12'h03C, 32'h00,  8'h0A, 32'h0A, 8'hFA, 4'd3},  // R3 partial mask
    '{1'b0, 12'h300, 32'h0,   8'h02, 32'hC0, 8'hFA, 4'd2},  // R2 masked read
    '{1'b1, 12'h400, 32'h05,  8'h02, 32'h05, 8'hCA, 4'd7},  // R7 float hold
    '{1'b0, 12'h3FC, 32'h0,   8'hFF, 32'hFA, 8'hCA, 4'd5},  // R5 capture
    '{1'b1, 12'h3FC, 32'hFF,  8'h00, 32'h05, 8'hCF, 4'd10}, // R10 collision
    '{1'b0, 12'hFE0, 32'h0,   8'h00, 32'h61, 8'hCF, 4'd8},  // R8
    '{1'b0, 12'hFFC, 32'h0,   8'h00, 32'hB1, 8'hCF, 4'd8},  // R8
    '{1'b0, 12'hFE4, 32'h0,   8'h00, 32'h10, 8'hCF, 4'd8},  // R8
    '{1'b1, 12'h404, 32'hFF,  8'h00, 32'h00, 8'hCF, 4'd9},  // R9
    '{1'b0, 12'h400, 32'h0,   8'h00, 32'h05, 8'hCF, 4'd9},  // R9 dir intact
    '{1'b1, 12'h800, 32'hFF,  8'h00, 32'h00, 8'hCF, 4'd9},  // R9
    '{1'b0, 12'h3FC, 32'h0,   8'h00, 32'h05, 8'hCF, 4'd9},  // R9 data intact
    '{1'b1, 12'h400, 32'h00,  8'h00, 32'h00, 8'hCF, 4'd7},  // R7
    '{1'b1, 12'h400, 32'h30,  8'h00, 32'h30, 8'hCF, 4'd6},  // R6
    '{1'b1, 12'h0C0, 32'h30,  8'h00, 32'h30, 8'hFF, 4'd6},  // R6 output drive
    '{1'b1, 12'h400, 32'h00,  8'h00, 32'h00, 8'hCF, 4'd6}   // R6 pull-down
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mask_port #(.PULL_UP(PU), .PULL_DOWN(PD)) i_gpio_mask_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readAt(input logic [11:0] a);
    @(negedge clk); busAddr = a; busWrEn = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 pin reset", 32'(pinOut), 32'h0F);
    check("R1 read reset", busRdData, 32'h0);
    @(negedge clk); rstN = 1'b1;
    readAt(12'h3FC); check("R1 data reset", busRdData, 32'h0);
    readAt(12'h400); check("R1 dir reset", busRdData, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      busAddr = VECS[v].addr; busWrEn = VECS[v].wr;
      busWrData = VECS[v].wdata; pinIn = VECS[v].pins;
      @(negedge clk); busWrEn = 1'b0;
      @(posedge clk); #1;
      check($sformatf("R%0d read v%0d", VECS[v].req, v), busRdData, VECS[v].expRd);
      check($sformatf("R%0d pins v%0d", VECS[v].req, v), 32'(pinOut), 32'(VECS[v].expOut));
    end

    // R1: reset in mid-run restores pull levels and clears the registers
    @(negedge clk); busAddr = 12'h400; busWrEn = 1'b1; busWrData = 32'hFF;
    @(negedge clk); busAddr = 12'h3FC; busWrData = 32'hAA;
    @(negedge clk); busWrEn = 1'b0;
    @(posedge clk); #1;
    check("R6 all out", 32'(pinOut), 32'hAA);
    rstN = 1'b0; #1;
    check("R1 async pins", 32'(pinOut), 32'h0F);
    check("R1 async read", busRdData, 32'h0);
    @(negedge clk); rstN = 1'b1;
    readAt(12'h400); check("R1 dir cleared", busRdData, 32'h0);
    readAt(12'h3FC); check("R1 data cleared", busRdData, 32'h0);
    readAt(12'hFD0); check("R8 first id", busRdData, 32'h0);
    readAt(12'hFF4); check("R8 id F0", busRdData, 32'hF0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule